// File: doc/BRIEF.md
# Interrupt-Aware Register Page Stack

This block holds the page select that qualifies every access an 8051-style core makes to its special-function-register window at direct addresses 0x80 to 0xFF. Each address in that window picks one register inside the active page. Up to 256 pages are possible. The active page sits at the top of a small hardware stack. When the interrupt controller accepts an interrupt, it pulses a strobe together with the page that holds the source's flag bit. The stack shifts down by one entry and the new page becomes active, so the service routine can reach its flags without switching pages first. On return from interrupt the stack shifts back up: the saved page becomes active again, and the bottom entry is refilled with zero.

Software can read and write every stack entry through a tiny address decode. These addresses are decoded on all pages, so the page select can always be reached. A software write changes only the addressed entry and never moves the stack. A handler can therefore overwrite a saved entry to choose which page becomes active after its return.

Top module: `page_ctx_stack`

## Requirements
- R1: While reset is asserted, and after it is released, every stack entry reads 0x00 and `act_page` is 0x00.
- R2: `act_page` always equals the top stack entry (entry 0).
- R3: A cycle with `irq_take` high and `irq_ret` low loads entry 0 with `irq_page`, entry 1 with the old entry 0 and entry 2 with the old entry 1, all on the same clock edge. The old bottom value is discarded.
- R4: A cycle with `irq_ret` high and `irq_take` low moves entry 1 into entry 0 and entry 2 into entry 1, and clears entry 2 to 0x00.
- R5: With both strobes low, `sw_wr` high and `sw_addr` equal to `ADDR_BASE + i` (i = 0 for the top entry, 1 for the middle entry, 2 for the bottom entry), entry i takes `sw_wdata` on the next edge. No other entry changes and the stack does not shift. A write to any other address changes nothing.
- R6: A cycle with both `irq_take` and `irq_ret` high leaves all entries unchanged, even if a software write is requested in that cycle.
- R7: When a software write coincides with a push or a pop, the push or pop is performed and the write is dropped.
- R8: Reads are combinational. When `sw_addr` equals `ADDR_BASE + i`, `sw_hit` is 1 and `sw_rdata` is entry i, whatever the active page. For any other address, `sw_hit` is 0 and `sw_rdata` is 0x00.
- R9: A value that software writes into entry 1 after a push becomes `act_page` after the following pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_take | input | 1 | One-cycle pulse: interrupt accepted, push the stack |
| irq_page | input | PAGE_W | Page holding the flag of the accepted interrupt |
| irq_ret | input | 1 | One-cycle pulse: return from interrupt, pop the stack |
| sw_wr | input | 1 | Software write strobe for a stack entry |
| sw_addr | input | ADDR_W | Direct address for software read and write |
| sw_wdata | input | PAGE_W | Software write data |
| sw_rdata | output | PAGE_W | Read data of the addressed entry, 0 when not decoded |
| sw_hit | output | 1 | High when `sw_addr` selects a stack entry |
| act_page | output | PAGE_W | Active page number |

## Verification
The bench builds the block with its default parameters: 8-bit pages, a three-entry stack and the entry addresses starting at 0xB1. With 8-bit pages, random page values cover the full range up to 0xFF. The random addresses are drawn from a window one slot wider than the three entries, so writes to the neighbouring undecoded address occur often, and the bench can confirm that they leave the stack unchanged. Because the stack is only three deep, random push runs regularly overflow and drop the bottom entry. Random pop runs regularly drain the stack to all zeros, which brings both the discard of the old bottom value and the zero refill within reach.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_WRITE = 2'd3
  } pg_op_e;
endpackage

// File: rtl/pgstk_decode.sv
module pgstk_decode #(
  parameter int ADDR_W    = 8,
  parameter int DEPTH     = 3,
  parameter int ADDR_BASE = 'hB1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:0]  sel,
  output logic              hit
);
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_sel
    assign sel[gi] = (addr == ADDR_W'(ADDR_BASE + gi));
  end
  assign hit = |sel;
endmodule

// File: rtl/pgstk_entries.sv
module pgstk_entries
  import pgstk_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pg_op_e                        op,
  input  logic [PAGE_W-1:0]             push_page,
  input  logic [DEPTH-1:0]              wr_sel,
  input  logic [PAGE_W-1:0]             wdata,
  output logic [DEPTH-1:0][PAGE_W-1:0]  stk
);
  logic [DEPTH-1:0][PAGE_W-1:0] stk_q, stk_d;
  logic                         stk_en;

  assign stk_en = (op != OP_HOLD);

  always_comb begin
    stk_d = stk_q;
    unique case (op)
      OP_PUSH: begin
        stk_d[0] = push_page;
        for (int i = 1; i < DEPTH; i++) stk_d[i] = stk_q[i-1];
      end
      OP_POP: begin
        for (int i = 0; i < DEPTH-1; i++) stk_d[i] = stk_q[i+1];
        stk_d[DEPTH-1] = '0;
      end
      OP_WRITE: begin
        for (int i = 0; i < DEPTH; i++)
          if (wr_sel[i]) stk_d[i] = wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stk_q <= '0;
    else if (stk_en) stk_q <= stk_d;
  end

  assign stk = stk_q;
endmodule

// File: rtl/page_ctx_stack.sv
module page_ctx_stack
  import pgstk_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int DEPTH     = 3,
  parameter int ADDR_BASE = 'hB1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic [PAGE_W-1:0] irq_page,
  input  logic              irq_ret,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [PAGE_W-1:0] sw_wdata,
  output logic [PAGE_W-1:0] sw_rdata,
  output logic              sw_hit,
  output logic [PAGE_W-1:0] act_page
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [DEPTH-1:0]             sel;
  logic [DEPTH-1:0][PAGE_W-1:0] stk;
  pg_op_e                       op;

  pgstk_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ADDR_BASE(ADDR_BASE)) u_dec (
    .addr (sw_addr),
    .sel  (sel),
    .hit  (sw_hit)
  );

  // interrupt events take priority; a clash freezes everything
  always_comb begin
    if (irq_take && irq_ret)   op = OP_HOLD;
    else if (irq_take)         op = OP_PUSH;
    else if (irq_ret)          op = OP_POP;
    else if (sw_wr && sw_hit)  op = OP_WRITE;
    else                       op = OP_HOLD;
  end

  pgstk_entries #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_ent (
    .clk       (clk),
    .rst_n     (rst_sync),
    .op        (op),
    .push_page (irq_page),
    .wr_sel    (sel),
    .wdata     (sw_wdata),
    .stk       (stk)
  );

  always_comb begin
    sw_rdata = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sel[i]) sw_rdata = stk[i];
  end

  assign act_page = stk[0];
endmodule

// File: rtl/page_ctx_stack_chk.sv
module page_ctx_stack_chk #(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3
) (
  input logic                         clk,
  input logic                         rst_ok,
  input logic                         irq_take,
  input logic [PAGE_W-1:0]            irq_page,
  input logic                         irq_ret,
  input logic                         sw_wr,
  input logic [PAGE_W-1:0]            act_page,
  input logic [DEPTH-1:0][PAGE_W-1:0] stk
);
  // R3: pushed page becomes active
  a_r3_push_load: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_take && !irq_ret) |=> act_page == $past(irq_page));
  // R3: old top moves down one entry
  a_r3_push_shift: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_take && !irq_ret) |=> stk[1] == $past(stk[0]));
  // R4: pop restores the saved page and clears the bottom
  a_r4_pop_restore: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_ret && !irq_take) |=> (stk[0] == $past(stk[1])) && (stk[DEPTH-1] == '0));
  // R6: simultaneous strobes freeze the stack
  a_r6_clash_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_take && irq_ret) |=> $stable(stk));
  // R5: without any event the stack cannot move
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!irq_take && !irq_ret && !sw_wr) |=> $stable(stk));
endmodule

bind page_ctx_stack page_ctx_stack_chk #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_sync),
  .irq_take (irq_take),
  .irq_page (irq_page),
  .irq_ret  (irq_ret),
  .sw_wr    (sw_wr),
  .act_page (act_page),
  .stk      (stk)
);

// File: tb/test_page_ctx_stack.sv
module test_page_ctx_stack;
  localparam int CLK_PERIOD = 10;
  localparam int PW    = 8;
  localparam int AW    = 8;
  localparam int DEP   = 3;
  localparam int BASE  = 'hB1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          irq_take, irq_ret, sw_wr;
  logic [PW-1:0] irq_page, sw_wdata, sw_rdata, act_page;
  logic [AW-1:0] sw_addr;
  logic          sw_hit;

  int errors = 0;
  int checks = 0;
  logic [PW-1:0] m [DEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_ctx_stack #(.PAGE_W(PW), .ADDR_W(AW), .DEPTH(DEP), .ADDR_BASE(BASE)) i_page_ctx_stack (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_page(irq_page),
    .irq_ret(irq_ret), .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .sw_hit(sw_hit), .act_page(act_page)
  );

  function automatic int addr_idx(logic [AW-1:0] a);
    int k = int'(a) - BASE;
    return (k >= 0 && k < DEP) ? k : -1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare active page and every entry through the read port
  task automatic check_all(string req);
    check(act_page == m[0], "R2", act_page, m[0]);
    sw_wr = 1'b0;
    for (int i = 0; i < DEP; i++) begin
      sw_addr = AW'(BASE + i);
      #1;
      check(sw_hit && sw_rdata == m[i], req, sw_rdata, m[i]);
    end
  endtask

  task automatic model_apply(bit t, logic [PW-1:0] pg, bit r, bit w,
                             logic [AW-1:0] a, logic [PW-1:0] d);
    int k = addr_idx(a);
    if (t && !r) begin
      for (int i = DEP-1; i > 0; i--) m[i] = m[i-1];
      m[0] = pg;
    end else if (r && !t) begin
      for (int i = 0; i < DEP-1; i++) m[i] = m[i+1];
      m[DEP-1] = '0;
    end else if (!t && !r && w && k >= 0) begin
      m[k] = d;
    end
  endtask

  task automatic step(bit t, logic [PW-1:0] pg, bit r, bit w,
                      logic [AW-1:0] a, logic [PW-1:0] d, string req);
    irq_take = t; irq_page = pg; irq_ret = r;
    sw_wr = w; sw_addr = a; sw_wdata = d;
    @(posedge clk);
    model_apply(t, pg, r, w, a, d);
    @(negedge clk);
    irq_take = 1'b0; irq_ret = 1'b0; sw_wr = 1'b0;
    check_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEP; i++) m[i] = '0;
    check_all("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    irq_take = 0; irq_ret = 0; sw_wr = 0;
    irq_page = 0; sw_addr = 0; sw_wdata = 0;
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    do_reset();

    // R3: three pushes, then a fourth that drops the bottom value
    step(1, 8'h0F, 0, 0, 0, 0, "R3");
    step(1, 8'h22, 0, 0, 0, 0, "R3");
    step(1, 8'h33, 0, 0, 0, 0, "R3");
    step(1, 8'hFF, 0, 0, 0, 0, "R3");
    // R9: rewrite the saved entry, then pop
    step(0, 0, 0, 1, AW'(BASE + 1), 8'h5A, "R5");
    step(0, 0, 1, 0, 0, 0, "R9");
    check(act_page == 8'h5A, "R9", act_page, 8'h5A);
    // R4: pop drains, bottom refills with zero
    step(0, 0, 1, 0, 0, 0, "R4");
    step(0, 0, 1, 0, 0, 0, "R4");
    check(act_page == 8'h00, "R4", act_page, 0);
    // R6: clash with a pending write leaves state
    step(0, 0, 0, 1, AW'(BASE), 8'h11, "R5");
    step(1, 8'h77, 1, 1, AW'(BASE), 8'h99, "R6");
    // R7: a push beats a write in the same cycle
    step(1, 8'h44, 0, 1, AW'(BASE + 2), 8'hEE, "R7");
    // R7: a pop beats a write in the same cycle
    step(0, 0, 1, 1, AW'(BASE), 8'hCC, "R7");
    // R5: write to an undecoded neighbour is ignored
    step(0, 0, 0, 1, AW'(BASE + DEP), 8'hAB, "R5");
    // R8: undecoded read returns zero without hit
    sw_addr = 8'h80; #1;
    check(!sw_hit && sw_rdata == 0, "R8", {sw_hit, sw_rdata}, 0);
    sw_addr = AW'(BASE - 1); #1;
    check(!sw_hit && sw_rdata == 0, "R8", {sw_hit, sw_rdata}, 0);

    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom % 8;
      logic [PW-1:0] pg = PW'($urandom);
      logic [PW-1:0] d  = PW'($urandom);
      logic [AW-1:0] a  = AW'(BASE + ($urandom % (DEP + 1)));
      case (sel)
        0, 1:    step(1, pg, 0, 0, a, d, "R3");
        2, 3:    step(0, pg, 1, 0, a, d, "R4");
        4, 5:    step(0, pg, 0, 1, a, d, "R5");
        6:       step(1, pg, 1, $urandom % 2, a, d, "R6");
        default: step($urandom % 2, pg, !irq_take && ($urandom % 2), 1, a, d, "R7");
      endcase
      if (n == 1500) do_reset();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule